// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs one channel of an external memory bus. It checks each internal access request against the channel's address window and asserts an active-low chip select for the whole access. It then times each beat with a programmed number of wait cycles, or holds the beat open until an external acknowledge input arrives. While the access runs, it drives active-low byte strobes. When a beat finishes, it returns a one-cycle done pulse to the requester.

The channel settings arrive as plain inputs: a 2-bit follow-on wait field, a 4-bit lead wait field, a 4-bit window size code, a strobe-style bit, a page-mode bit and a window base address. The block copies these settings when it accepts an access, so a later change to them does not affect that access.

The controller has four states:
- `S_IDLE` waits for a request. On a request that hits the window, it goes to `S_WAIT`. If acknowledge termination is selected, it goes to `S_ACKW` instead.
- `S_WAIT` counts wait cycles down. It goes to `S_DONE` when the count is zero.
- `S_ACKW` holds until `ext_ack` is sampled high, then goes to `S_DONE`.
- `S_DONE` raises the done pulse. It returns to `S_IDLE` after the last beat. Otherwise it reloads the counter for the next beat and re-enters `S_WAIT` or `S_ACKW`.

Top module: `ebus_wait_seq`

## Requirements
- R1: A request hits the window when its address bits from bit 20+k upward equal the same bits of `cfg_base`, where k is the effective size code and the window spans 2^(20+k) bytes. A request that misses is ignored: `cs_n` stays high and `beat_done` stays low.
- R2: Size codes 11 to 15 never hit, for any address.
- R3: With a 16-bit memory bus the effective size code is capped at 9 (512 MB). With an 8-bit bus it is capped at 8 (256 MB). A 32-bit bus allows up to code 10.
- R4: In page mode, the first beat waits `cfg_wt` cycles (0..15). Count the accepting clock edge as edge 1. Then `beat_done` is high after edge `cfg_wt`+2, for exactly one cycle.
- R5: In page mode, each later beat of a burst waits `cfg_pwt` cycles (0..3). Its `beat_done` follows the previous one by `cfg_pwt`+2 edges.
- R6: Outside page mode, every beat waits {`cfg_pwt`,`cfg_wt`} cycles (0..62), with `cfg_pwt` as the upper two bits. The first done is at edge n+2 and later dones follow every n+2 edges.
- R7: Outside page mode, a combined wait value of 6'h3F selects acknowledge termination. A beat then ends only on `ext_ack`: `beat_done` is high after the edge following the edge that samples `ext_ack` high. In page mode, the same field values (wt=15, pwt=3) are ordinary wait counts.
- R8: `strb_n` is all ones when no access is running. During an access with strobe bit 0, `strb_n` is `~req_lanes` for both reads and writes. With strobe bit 1, it is `~req_lanes` for writes and all ones for reads.
- R9: `cs_n` is high after reset. It goes low on the edge that accepts a request and stays low through the last `beat_done` cycle. It is high again on the next cycle.
- R10: `cfg_err` is high exactly when page mode is set and `cfg_wt` is less than `cfg_pwt`.
- R11: Wait fields, mode bits and request fields are captured when a request is accepted. A change to the configuration inputs during an access does not alter that access's beat timing.
- R12: An access carries `req_len`+1 beats, after which the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwt | input | 2 | Follow-on wait field; upper wait bits outside page mode |
| cfg_wt | input | 4 | Lead wait field; lower wait bits outside page mode |
| cfg_size | input | 4 | Window size code |
| cfg_bc | input | 1 | Strobe style: 0 = strobe on reads and writes, 1 = strobe on writes only |
| cfg_page | input | 1 | Page mode select |
| cfg_base | input | ADDR_W | Window base address |
| req_valid | input | 1 | Access request, taken only in idle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lanes | input | LANES | Byte lanes in use, active high |
| req_len | input | BLEN_W | Number of beats minus one |
| ext_ack | input | 1 | External acknowledge |
| cs_n | output | 1 | Chip select, active low |
| strb_n | output | LANES | Byte strobes, active low |
| beat_done | output | 1 | One-cycle done pulse for each finished beat |
| cfg_err | output | 1 | Page-mode wait configuration error |

## Verification
Every result is timed from the edge that accepts a request. Chip select and strobes are already valid at the negative edge after that edge. The first done pulse appears wait+2 edges after acceptance. Each later pulse appears wait+2 edges after the previous one. In acknowledge mode, the pulse appears one edge after `ext_ack` is sampled. The bench drives inputs at negative edges and counts positive edges from acceptance. At each negative edge it records the edge count at which `beat_done` was seen, then compares that count with the value computed from the fields. `cfg_err` is combinational and is checked in the same half cycle in which its inputs change.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    localparam int MB_SHIFT  = 20;
    localparam int MAX_CODE  = 10;
    localparam logic [5:0] ACK_WAIT = 6'h3F;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_ACKW = 2'd2,
        S_DONE = 2'd3
    } seq_state_t;

    function automatic int size_cap(input int bus_w);
        if (bus_w <= 8)
            return 8;
        else if (bus_w <= 16)
            return 9;
        else
            return MAX_CODE;
    endfunction
endpackage

// File: rtl/ebus_win_dec.sv
module ebus_win_dec
    import ebus_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MEM_BUS_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        size_code,
    output logic              hit
);
    localparam int          CAP   = size_cap(MEM_BUS_W);
    localparam logic [3:0]  CAP_C = 4'(CAP);

    logic [3:0]        eff_code;
    logic [5:0]        low_bits;
    logic [ADDR_W-1:0] low_mask;
    logic              code_ok;

    always_comb begin
        code_ok  = (size_code <= 4'(MAX_CODE));
        eff_code = (size_code > CAP_C) ? CAP_C : size_code;
        low_bits = 6'(MB_SHIFT) + {2'b00, eff_code};
        low_mask = ({{(ADDR_W-1){1'b0}}, 1'b1} << low_bits) - 1'b1;
        hit      = code_ok && (((addr ^ base) & ~low_mask) == '0);
    end
endmodule

// File: rtl/ebus_wait_cnt.sv
module ebus_wait_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ebus_wait_seq.sv
module ebus_wait_seq
    import ebus_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MEM_BUS_W = 16,
    parameter int LANES     = 4,
    parameter int BLEN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_pwt,
    input  logic [3:0]        cfg_wt,
    input  logic [3:0]        cfg_size,
    input  logic              cfg_bc,
    input  logic              cfg_page,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [BLEN_W-1:0] req_len,
    input  logic              ext_ack,
    output logic              cs_n,
    output logic [LANES-1:0]  strb_n,
    output logic              beat_done,
    output logic              cfg_err
);
    localparam int CNT_W = 6;

    seq_state_t        st, st_nxt;
    logic              hit, accept, cnt_load, cnt_expired;
    logic [CNT_W-1:0]  cnt_val;
    logic              live_ack, held_ack;
    logic [CNT_W-1:0]  live_first, held_next;

    logic              h_page, h_bc, h_wr;
    logic [1:0]        h_pwt;
    logic [3:0]        h_wt;
    logic [LANES-1:0]  h_lanes;
    logic [BLEN_W-1:0] beats_left;

    ebus_win_dec #(.ADDR_W(ADDR_W), .MEM_BUS_W(MEM_BUS_W)) u_win (
        .addr      (req_addr),
        .base      (cfg_base),
        .size_code (cfg_size),
        .hit       (hit)
    );

    ebus_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    // Wait values: live fields for the lead beat, held fields afterwards.
    always_comb begin
        live_first = cfg_page ? {2'b00, cfg_wt} : {cfg_pwt, cfg_wt};
        live_ack   = !cfg_page && ({cfg_pwt, cfg_wt} == ACK_WAIT);
        held_next  = h_page ? {4'b0000, h_pwt} : {h_pwt, h_wt};
        held_ack   = !h_page && ({h_pwt, h_wt} == ACK_WAIT);
    end

    // Next-state and counter-load decode.
    always_comb begin
        st_nxt   = st;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (req_valid && hit) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    cnt_val  = live_first;
                    st_nxt   = live_ack ? S_ACKW : S_WAIT;
                end
            end
            S_WAIT: begin
                if (cnt_expired)
                    st_nxt = S_DONE;
            end
            S_ACKW: begin
                if (ext_ack)
                    st_nxt = S_DONE;
            end
            S_DONE: begin
                if (beats_left == '0) begin
                    st_nxt = S_IDLE;
                end else begin
                    cnt_load = 1'b1;
                    cnt_val  = held_next;
                    st_nxt   = held_ack ? S_ACKW : S_WAIT;
                end
            end
            default: st_nxt = S_IDLE;
        endcase
    end

    // State register and access capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            h_page     <= 1'b0;
            h_bc       <= 1'b0;
            h_wr       <= 1'b0;
            h_pwt      <= '0;
            h_wt       <= '0;
            h_lanes    <= '0;
            beats_left <= '0;
        end else begin
            st <= st_nxt;
            if (accept) begin
                h_page     <= cfg_page;
                h_bc       <= cfg_bc;
                h_wr       <= req_write;
                h_pwt      <= cfg_pwt;
                h_wt       <= cfg_wt;
                h_lanes    <= req_lanes;
                beats_left <= req_len;
            end else if (st == S_DONE && beats_left != '0) begin
                beats_left <= beats_left - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        cs_n      = (st == S_IDLE);
        beat_done = (st == S_DONE);
        strb_n    = (st != S_IDLE && (!h_bc || h_wr)) ? ~h_lanes : '1;
        cfg_err   = cfg_page && (cfg_wt < {2'b00, cfg_pwt});
    end
endmodule

// File: rtl/ebus_wait_seq_chk.sv
module ebus_wait_seq_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             cs_n,
    input logic [LANES-1:0] strb_n,
    input logic             beat_done,
    input logic             ext_ack,
    input logic             in_ack,
    input logic             held_bc,
    input logic             held_wr
);
    p_done_inside_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> !cs_n);

    p_start_on_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req_valid));

    p_idle_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (strb_n == '1));

    p_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && held_bc && !held_wr) |-> (strb_n == '1));

    p_ack_ends_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && ext_ack) |=> beat_done);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |=> !beat_done);
endmodule

bind ebus_wait_seq ebus_wait_seq_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cs_n      (cs_n),
    .strb_n    (strb_n),
    .beat_done (beat_done),
    .ext_ack   (ext_ack),
    .in_ack    (st == ebus_pkg::S_ACKW),
    .held_bc   (h_bc),
    .held_wr   (h_wr)
);

// File: tb/sim_ebus_wait_seq.sv
`timescale 1ns/1ps
module sim_ebus_wait_seq;
    localparam int ADDR_W = 32;
    localparam int LANES  = 4;
    localparam int BLEN_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_pwt = '0;
    logic [3:0]        cfg_wt = '0;
    logic [3:0]        cfg_size = '0;
    logic              cfg_bc = 1'b0;
    logic              cfg_page = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic [LANES-1:0]  req_lanes = '0;
    logic [BLEN_W-1:0] req_len = '0;
    logic              ext_ack = 1'b0;
    logic              cs_n;
    logic [LANES-1:0]  strb_n;
    logic              beat_done;
    logic              cfg_err;

    int checks = 0;
    int errors = 0;
    int done_at [0:15];
    int ndone;
    int first_cs, first_strb, end_cs;

    always #5 clk = ~clk;

    ebus_wait_seq #(.ADDR_W(ADDR_W), .MEM_BUS_W(16), .LANES(LANES), .BLEN_W(BLEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pwt(cfg_pwt), .cfg_wt(cfg_wt),
        .cfg_size(cfg_size), .cfg_bc(cfg_bc), .cfg_page(cfg_page),
        .cfg_base(cfg_base), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_lanes(req_lanes), .req_len(req_len),
        .ext_ack(ext_ack), .cs_n(cs_n), .strb_n(strb_n),
        .beat_done(beat_done), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one access; ack_at/chg_at are edge counts (0 = never).
    task automatic run_access(input logic [ADDR_W-1:0] addr, input logic wr,
                              input logic [LANES-1:0] lanes, input int len,
                              input int ack_at, input int chg_at);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr;
        req_lanes = lanes; req_len = BLEN_W'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; ndone = 0;
        first_cs = int'(cs_n); first_strb = int'(strb_n);
        while (ndone < len + 1 && n < 400) begin
            if (beat_done) begin
                done_at[ndone] = n;
                ndone++;
            end
            ext_ack = (n == ack_at);
            if (n == chg_at) begin
                cfg_wt = 4'd0; cfg_pwt = 2'd0;
            end
            if (ndone < len + 1) begin
                @(posedge clk); @(negedge clk); n++;
            end
        end
        ext_ack = 1'b0;
        check("R12 beat count", ndone, len + 1);
        @(posedge clk); @(negedge clk);
        end_cs = int'(cs_n);
    endtask

    task automatic try_miss(input string tag, input logic [ADDR_W-1:0] addr);
        int seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!cs_n || beat_done) seen = 1;
            @(negedge clk);
        end
        check(tag, seen, 0);
    endtask

    task automatic t_reset;
        check("R9 reset cs_n", int'(cs_n), 1);
        check("R8 reset strb_n", int'(strb_n), 15);
        check("R4 reset beat_done", int'(beat_done), 0);
    endtask

    task automatic t_page_burst;
        cfg_page = 1; cfg_wt = 5; cfg_pwt = 2; cfg_bc = 0;
        cfg_size = 4'd4; cfg_base = 32'h0100_0000;
        run_access(32'h0100_0040, 1'b0, 4'b0101, 3, 0, 0);
        check("R9 cs low during access", first_cs, 0);
        check("R8 byte enable on read", first_strb, 4'b1010);
        check("R4 page first beat", done_at[0], 7);
        check("R5 page beat 2", done_at[1], 11);
        check("R5 page beat 4", done_at[3], 19);
        check("R9 cs high after last", end_cs, 1);
    endtask

    task automatic t_normal;
        cfg_page = 0; cfg_pwt = 1; cfg_wt = 3;
        run_access(32'h0100_0000, 1'b1, 4'b1111, 1, 0, 0);
        check("R6 normal first beat", done_at[0], 21);
        check("R6 normal second beat", done_at[1], 42);
    endtask

    task automatic t_ack;
        cfg_page = 0; cfg_pwt = 3; cfg_wt = 15;
        run_access(32'h0100_0000, 1'b0, 4'b0001, 0, 6, 0);
        check("R7 ack terminated beat", done_at[0], 7);
        cfg_page = 1;
        run_access(32'h0100_0000, 1'b0, 4'b0001, 0, 3, 0);
        check("R7 page mode ignores ack code", done_at[0], 17);
    endtask

    task automatic t_strobe_write_only;
        cfg_page = 0; cfg_pwt = 0; cfg_wt = 2; cfg_bc = 1;
        run_access(32'h0100_0000, 1'b0, 4'b1111, 0, 0, 0);
        check("R8 write-only strobe quiet on read", first_strb, 15);
        run_access(32'h0100_0000, 1'b1, 4'b0011, 0, 0, 0);
        check("R8 write-only strobe on write", first_strb, 4'b1100);
        cfg_bc = 0;
        run_access(32'h0100_0000, 1'b1, 4'b0110, 0, 0, 0);
        check("R8 byte enable on write", first_strb, 4'b1001);
    endtask

    task automatic t_window;
        cfg_page = 0; cfg_pwt = 0; cfg_wt = 0;
        cfg_size = 4'd1; cfg_base = 32'h0030_0000;
        run_access(32'h0021_0000, 1'b0, 4'b1111, 0, 0, 0);
        check("R1 hit inside 2MB window", done_at[0], 2);
        try_miss("R1 miss above window", 32'h0040_0000);
        cfg_size = 4'd11; cfg_base = 32'h0000_0000;
        try_miss("R2 reserved code 11", 32'h0000_0100);
        cfg_size = 4'd15;
        try_miss("R2 reserved code 15", 32'h0000_0100);
    endtask

    task automatic t_clamp;
        cfg_base = 32'h0000_0000; cfg_size = 4'd10;
        try_miss("R3 code 10 capped to 512MB", 32'h2000_0000);
        run_access(32'h1FFF_FFF0, 1'b0, 4'b1111, 0, 0, 0);
        check("R3 capped window top hit", done_at[0], 2);
    endtask

    task automatic t_cfg_err;
        cfg_page = 1; cfg_wt = 1; cfg_pwt = 2;
        #1 check("R10 error when lead below follow-on", int'(cfg_err), 1);
        cfg_wt = 2;
        #1 check("R10 no error when equal", int'(cfg_err), 0);
        cfg_page = 0; cfg_wt = 0; cfg_pwt = 3;
        #1 check("R10 no error outside page mode", int'(cfg_err), 0);
    endtask

    task automatic t_sample;
        cfg_base = 32'h0; cfg_size = 4'd0;
        cfg_page = 0; cfg_pwt = 0; cfg_wt = 8;
        run_access(32'h0000_0010, 1'b0, 4'b1111, 1, 0, 3);
        check("R11 held wait beat 1", done_at[0], 10);
        check("R11 held wait beat 2", done_at[1], 20);
    endtask

    initial begin
        #1;
        t_reset;
        #24 rst_n = 1'b1;
        t_page_burst;
        t_normal;
        t_ack;
        t_strobe_write_only;
        t_window;
        t_clamp;
        t_cfg_err;
        t_sample;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule